// File: doc/BRIEF.md
# Serial NOR Flash Identification Probe

This block finds out which serial NOR flash sits on a byte-level SPI master. It runs by itself once after reset. The host can also start it again with a one-cycle request. The block asks the SPI master to assert chip select and holds it for a single frame. In that frame it sends the read-identification opcode, then clocks in three reply bytes by sending a filler byte three times.

The three reply bytes are stored. The first two are compared against the expected vendor code and device-family code, which are parameters. The third byte, the size code, is decoded into a full geometry set: erase-sector shift and count, program-page shift and count, and a sub-sector shift where the part has one. An unknown size code is rejected in the same way as a wrong vendor or family code: the block flags that no device was found and sets the geometry to zero. The result sits behind a done flag that stays high until the next probe starts.

The SPI master side uses a request/acknowledge pair. `xfer_go` stays high with the byte on `xfer_tx` until the master pulses `xfer_done` for one cycle with the byte it shifted in on `xfer_rx`. The bit-level shifter belongs to the master and is not part of this block.

Top module: `flashid_probe`

## Requirements
- R1: With `AUTO_PROBE` set (default 1), one probe starts without a request in the first cycle after reset is released. Its frame holds `cs_req` high across exactly four byte transfers.
- R2: Within the frame, the first byte on `xfer_tx` is 0x9F and the next three are 0xA5.
- R3: The reply bytes to the three filler transfers are taken, in order, as vendor code, family code and size code. The vendor and family codes must equal `VENDOR_ID` and `FAMILY_ID` (both 0x20 by default) for the device to be accepted.
- R4: Size code 0x11 gives sector shift 15, 4 sectors, page shift 8, 512 pages and sub-sector shift 0.
- R5: Size code 0x14 gives sector shift 16, 16 sectors, page shift 8, 4096 pages and sub-sector shift 12.
- R6: Size code 0x16 gives 16/64 sectors/16384 pages. Size code 0x17 gives 16/128/32768. Size code 0x18 gives 18/64/65536. Each lists sector shift, sector count and page count, and all three use page shift 8 and sub-sector shift 0.
- R7: A vendor mismatch, a family mismatch or a size code outside the five above ends the probe with `no_device` high, `id_valid` low and every geometry output zero.
- R8: `cs_req` falls at least one cycle before `done` rises. At the end of a probe, exactly one of `id_valid` and `no_device` is high while `done` is high.
- R9: A `probe_req` that arrives while a probe is running (`busy` high) is ignored and starts no further frame.
- R10: `done`, the result flags and the geometry outputs keep their values until the next probe starts, whatever the SPI side returns in the meantime.
- R11: During reset, `cs_req`, `xfer_go`, `busy`, `done`, `id_valid` and `no_device` are all low.
- R12: `xfer_go` is high only while `cs_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| probe_req | input | 1 | One-cycle request to start a probe |
| cs_req | output | 1 | Chip select request to the SPI master, active high |
| xfer_go | output | 1 | Byte transfer request, held until acknowledged |
| xfer_tx | output | 8 | Byte to shift out |
| xfer_done | input | 1 | One-cycle acknowledge that a byte transfer finished |
| xfer_rx | input | 8 | Byte shifted in during the finished transfer |
| busy | output | 1 | Probe in progress |
| done | output | 1 | Probe finished; result valid |
| id_valid | output | 1 | Device recognised |
| no_device | output | 1 | Device not recognised |
| sect_shift | output | 5 | log2 of erase-sector size in bytes |
| sect_count | output | 16 | Number of erase sectors |
| page_shift | output | 5 | log2 of program-page size in bytes |
| page_count | output | 32 | Number of program pages |
| sub_shift | output | 5 | log2 of sub-sector size, 0 if none |

## Verification
Every size code the block knows is probed once with matching vendor and family codes. This shows that each size code leads to its own geometry set, including the one case with a sub-sector shift. Three rejection patterns follow: a wrong vendor, a wrong family and a size code that lies between two valid ones. Together they show that each of the three reply bytes is checked, and that the byte order on the wire matters. A request made in the middle of a frame tells a correctly ignored request apart from a second frame. Changing the bench's reply bytes after a probe, with no new request, tells held results apart from outputs that follow the bus.

// File: rtl/flashid_pkg.sv
package flashid_pkg;

    localparam int BYTE_W     = 8;
    localparam int ID_BYTES   = 3;
    localparam int IDX_W      = $clog2(ID_BYTES + 1);
    localparam int SLOT_W     = $clog2(ID_BYTES);
    localparam int SHIFT_W    = 5;
    localparam int SECT_CNT_W = 16;
    localparam int PAGE_CNT_W = 32;

    localparam logic [BYTE_W-1:0] OP_READ_ID = 8'h9F;
    localparam logic [BYTE_W-1:0] FILLER     = 8'hA5;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_XFER,
        ST_DESEL
    } seq_st_e;

    typedef struct packed {
        logic [SHIFT_W-1:0]    sect_shift;
        logic [SECT_CNT_W-1:0] sect_cnt;
        logic [SHIFT_W-1:0]    page_shift;
        logic [PAGE_CNT_W-1:0] page_cnt;
        logic [SHIFT_W-1:0]    sub_shift;
    } geom_t;

    typedef struct packed {
        logic  known;
        geom_t g;
    } capdec_t;

    // Size code to geometry; page count derived from sector count and shifts.
    function automatic capdec_t decode_size(input logic [BYTE_W-1:0] code);
        capdec_t r;
        r              = '0;
        r.known        = 1'b1;
        r.g.page_shift = SHIFT_W'(8);
        case (code)
            8'h11: begin
                r.g.sect_shift = SHIFT_W'(15);
                r.g.sect_cnt   = SECT_CNT_W'(4);
            end
            8'h14: begin
                r.g.sect_shift = SHIFT_W'(16);
                r.g.sect_cnt   = SECT_CNT_W'(16);
                r.g.sub_shift  = SHIFT_W'(12);
            end
            8'h16: begin
                r.g.sect_shift = SHIFT_W'(16);
                r.g.sect_cnt   = SECT_CNT_W'(64);
            end
            8'h17: begin
                r.g.sect_shift = SHIFT_W'(16);
                r.g.sect_cnt   = SECT_CNT_W'(128);
            end
            8'h18: begin
                r.g.sect_shift = SHIFT_W'(18);
                r.g.sect_cnt   = SECT_CNT_W'(64);
            end
            default: r = '0;
        endcase
        if (r.known) begin
            r.g.page_cnt = PAGE_CNT_W'(r.g.sect_cnt) << (r.g.sect_shift - r.g.page_shift);
        end
        return r;
    endfunction

endpackage

// File: rtl/flashid_seq.sv
module flashid_seq
    import flashid_pkg::*;
#(
    parameter bit AUTO_PROBE = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              probe_req,
    input  logic              xfer_done,
    output logic              start,
    output logic              busy,
    output logic              cs_req,
    output logic              xfer_go,
    output logic [BYTE_W-1:0] xfer_tx,
    output logic              cap_we,
    output logic [SLOT_W-1:0] cap_idx,
    output logic              finish
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ID_BYTES);

    seq_st_e          st;
    logic [IDX_W-1:0] idx;
    logic             pend;

    assign busy    = (st != ST_IDLE);
    assign start   = (st == ST_IDLE) && (probe_req || pend);
    assign xfer_go = (st == ST_XFER);
    assign xfer_tx = (idx == '0) ? OP_READ_ID : FILLER;
    assign cap_we  = xfer_go && xfer_done && (idx != '0);
    assign cap_idx = SLOT_W'(idx - IDX_W'(1));
    assign finish  = (st == ST_DESEL);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            idx    <= '0;
            cs_req <= 1'b0;
            pend   <= AUTO_PROBE;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        pend   <= 1'b0;
                        cs_req <= 1'b1;
                        idx    <= '0;
                        st     <= ST_XFER;
                    end
                end
                ST_XFER: begin
                    if (xfer_done) begin
                        if (idx == LAST_IDX) begin
                            cs_req <= 1'b0;
                            st     <= ST_DESEL;
                        end else begin
                            idx <= idx + IDX_W'(1);
                        end
                    end
                end
                ST_DESEL: st <= ST_IDLE;
                default:  st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/flashid_idregs.sv
module flashid_idregs
    import flashid_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           cap_we,
    input  logic [SLOT_W-1:0]              cap_idx,
    input  logic [BYTE_W-1:0]              rx_byte,
    output logic [ID_BYTES-1:0][BYTE_W-1:0] id_bytes
);

    for (genvar s = 0; s < ID_BYTES; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                id_bytes[s] <= '0;
            end else if (cap_we && (cap_idx == SLOT_W'(s))) begin
                id_bytes[s] <= rx_byte;
            end
        end
    end

endmodule

// File: rtl/flashid_judge.sv
module flashid_judge
    import flashid_pkg::*;
#(
    parameter logic [7:0] VENDOR_ID = 8'h20,
    parameter logic [7:0] FAMILY_ID = 8'h20
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            start,
    input  logic                            finish,
    input  logic [ID_BYTES-1:0][BYTE_W-1:0] id_bytes,
    output logic                            done,
    output logic                            id_valid,
    output logic                            no_device,
    output geom_t                           geom
);

    capdec_t dec;
    logic    accept;

    assign dec    = decode_size(id_bytes[2]);
    assign accept = (id_bytes[0] == VENDOR_ID) && (id_bytes[1] == FAMILY_ID) && dec.known;

    always_ff @(posedge clk) begin
        if (rst) begin
            done      <= 1'b0;
            id_valid  <= 1'b0;
            no_device <= 1'b0;
            geom      <= '0;
        end else if (start) begin
            done      <= 1'b0;
            id_valid  <= 1'b0;
            no_device <= 1'b0;
        end else if (finish) begin
            done      <= 1'b1;
            id_valid  <= accept;
            no_device <= !accept;
            geom      <= accept ? dec.g : '0;
        end
    end

endmodule

// File: rtl/flashid_probe.sv
module flashid_probe
    import flashid_pkg::*;
#(
    parameter logic [7:0] VENDOR_ID  = 8'h20,
    parameter logic [7:0] FAMILY_ID  = 8'h20,
    parameter bit         AUTO_PROBE = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        probe_req,
    output logic        cs_req,
    output logic        xfer_go,
    output logic [7:0]  xfer_tx,
    input  logic        xfer_done,
    input  logic [7:0]  xfer_rx,
    output logic        busy,
    output logic        done,
    output logic        id_valid,
    output logic        no_device,
    output logic [4:0]  sect_shift,
    output logic [15:0] sect_count,
    output logic [4:0]  page_shift,
    output logic [31:0] page_count,
    output logic [4:0]  sub_shift
);

    logic                            start;
    logic                            finish;
    logic                            cap_we;
    logic [SLOT_W-1:0]               cap_idx;
    logic [ID_BYTES-1:0][BYTE_W-1:0] id_bytes;
    geom_t                           geom;

    flashid_seq #(.AUTO_PROBE(AUTO_PROBE)) seq_i (
        .clk       (clk),
        .rst       (rst),
        .probe_req (probe_req),
        .xfer_done (xfer_done),
        .start     (start),
        .busy      (busy),
        .cs_req    (cs_req),
        .xfer_go   (xfer_go),
        .xfer_tx   (xfer_tx),
        .cap_we    (cap_we),
        .cap_idx   (cap_idx),
        .finish    (finish)
    );

    flashid_idregs idregs_i (
        .clk      (clk),
        .rst      (rst),
        .cap_we   (cap_we),
        .cap_idx  (cap_idx),
        .rx_byte  (xfer_rx),
        .id_bytes (id_bytes)
    );

    flashid_judge #(.VENDOR_ID(VENDOR_ID), .FAMILY_ID(FAMILY_ID)) judge_i (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .finish    (finish),
        .id_bytes  (id_bytes),
        .done      (done),
        .id_valid  (id_valid),
        .no_device (no_device),
        .geom      (geom)
    );

    assign sect_shift = geom.sect_shift;
    assign sect_count = geom.sect_cnt;
    assign page_shift = geom.page_shift;
    assign page_count = geom.page_cnt;
    assign sub_shift  = geom.sub_shift;

endmodule

// File: rtl/flashid_probe_chk.sv
module flashid_probe_chk (
    input logic        clk,
    input logic        rst,
    input logic        cs_req,
    input logic        xfer_go,
    input logic        busy,
    input logic        done,
    input logic        id_valid,
    input logic        no_device,
    input logic [4:0]  sect_shift,
    input logic [15:0] sect_count,
    input logic [31:0] page_count,
    input logic [4:0]  sub_shift
);

    // R12
    go_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_go |-> cs_req);

    // R8
    cs_before_done_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> !$past(cs_req));

    // R8
    one_verdict_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (id_valid ^ no_device));

    // R8
    no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        !(done && cs_req));

    // R10
    geom_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$rose(done) |-> ($stable(sect_shift) && $stable(sect_count)
                          && $stable(page_count) && $stable(sub_shift)));

    // R7
    reject_zero_chk: assert property (@(posedge clk) disable iff (rst)
        no_device |-> (sect_count == 16'd0 && page_count == 32'd0));

    // R11
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (!done && !id_valid && !no_device));

    // R9
    busy_frame_chk: assert property (@(posedge clk) disable iff (rst)
        cs_req |-> busy);

endmodule

bind flashid_probe flashid_probe_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .cs_req     (cs_req),
    .xfer_go    (xfer_go),
    .busy       (busy),
    .done       (done),
    .id_valid   (id_valid),
    .no_device  (no_device),
    .sect_shift (sect_shift),
    .sect_count (sect_count),
    .page_count (page_count),
    .sub_shift  (sub_shift)
);

// File: tb/flashid_probe_tb.sv
`timescale 1ns/1ps
module flashid_probe_tb_top;

    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        probe_req = 1'b0;
    logic        cs_req, xfer_go, busy, done, id_valid, no_device;
    logic [7:0]  xfer_tx;
    logic        xfer_done = 1'b0;
    logic [7:0]  xfer_rx = 8'h00;
    logic [4:0]  sect_shift, page_shift, sub_shift;
    logic [15:0] sect_count;
    logic [31:0] page_count;

    int checks = 0;
    int fails  = 0;

    logic [7:0] resp [3];
    logic       m_busy;
    int         m_cnt, fidx, frames, seq_bad;
    logic       cs_prev;

    always #2 clk = ~clk;

    flashid_probe dut_i (
        .clk(clk), .rst(rst), .probe_req(probe_req),
        .cs_req(cs_req), .xfer_go(xfer_go), .xfer_tx(xfer_tx),
        .xfer_done(xfer_done), .xfer_rx(xfer_rx),
        .busy(busy), .done(done), .id_valid(id_valid), .no_device(no_device),
        .sect_shift(sect_shift), .sect_count(sect_count),
        .page_shift(page_shift), .page_count(page_count), .sub_shift(sub_shift)
    );

    // SPI master model: fixed latency per byte, checks opcode/filler order.
    always @(posedge clk) begin
        xfer_done <= 1'b0;
        cs_prev   <= cs_req;
        if (rst) begin
            m_busy  <= 1'b0;
            m_cnt   <= 0;
            fidx    <= 0;
            frames  <= 0;
            seq_bad <= 0;
        end else begin
            if (cs_prev && !cs_req && fidx != 4) seq_bad <= seq_bad + 1;
            if (!cs_req) fidx <= 0;
            if (!m_busy && xfer_go && !xfer_done) begin
                m_busy <= 1'b1;
                m_cnt  <= LAT;
                if (xfer_tx != ((fidx == 0) ? 8'h9F : 8'hA5)) seq_bad <= seq_bad + 1;
                if (fidx == 0) frames <= frames + 1;
            end else if (m_busy) begin
                if (m_cnt == 0) begin
                    xfer_done <= 1'b1;
                    xfer_rx   <= (fidx == 0) ? 8'hFF : resp[fidx-1];
                    fidx      <= fidx + 1;
                    m_busy    <= 1'b0;
                    if (fidx >= 4) seq_bad <= seq_bad + 1;
                end else begin
                    m_cnt <= m_cnt - 1;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 500) begin
            @(negedge clk);
            n++;
        end
        chk(done == 1'b1, "R8 done reached", done, 1);
    endtask

    task automatic pulse_req();
        @(negedge clk);
        probe_req = 1'b1;
        @(negedge clk);
        probe_req = 1'b0;
    endtask

    task automatic set_resp(input logic [7:0] v, input logic [7:0] t, input logic [7:0] c);
        resp[0] = v;
        resp[1] = t;
        resp[2] = c;
    endtask

    task automatic check_geom(input string tag, input int ss, input int sc,
                              input int ps, input int pc, input int sub);
        chk(id_valid && !no_device, {tag, " id_valid"}, id_valid, 1);
        chk(sect_shift == 5'(ss), {tag, " sect_shift"}, sect_shift, ss);
        chk(sect_count == 16'(sc), {tag, " sect_count"}, sect_count, sc);
        chk(page_shift == 5'(ps), {tag, " page_shift"}, page_shift, ps);
        chk(page_count == 32'(pc), {tag, " page_count"}, page_count, pc);
        chk(sub_shift == 5'(sub), {tag, " sub_shift"}, sub_shift, sub);
    endtask

    task automatic probe_ok(input logic [7:0] c, input string tag, input int ss, input int sc,
                            input int pc, input int sub);
        int f0;
        set_resp(8'h20, 8'h20, c);
        f0 = frames;
        pulse_req();
        wait_done();
        chk(frames == f0 + 1, {tag, " R2 one frame"}, frames - f0, 1);
        chk(!cs_req, {tag, " R8 cs low at done"}, cs_req, 0);
        check_geom(tag, ss, sc, 8, pc, sub);
    endtask

    task automatic probe_bad(input logic [7:0] v, input logic [7:0] t, input logic [7:0] c,
                             input string tag);
        set_resp(v, t, c);
        pulse_req();
        wait_done();
        chk(no_device && !id_valid, {tag, " no_device"}, no_device, 1);
        chk(sect_count == 0 && page_count == 0 && sect_shift == 0 && sub_shift == 0,
            {tag, " geometry zero"}, page_count, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!cs_req && !xfer_go && !busy, "R11 spi idle in reset", {cs_req, xfer_go, busy}, 0);
        chk(!done && !id_valid && !no_device, "R11 flags low in reset",
            {done, id_valid, no_device}, 0);
    endtask

    task automatic t_auto();
        set_resp(8'h20, 8'h20, 8'h17);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy && cs_req, "R1 auto start", {busy, cs_req}, 3);
        wait_done();
        chk(frames == 1, "R1 single frame", frames, 1);
        chk(seq_bad == 0, "R1 R2 byte sequence", seq_bad, 0);
        check_geom("R6 R3 0x17 auto", 16, 128, 8, 32768, 0);
    endtask

    task automatic t_ignore();
        int f0;
        set_resp(8'h20, 8'h20, 8'h16);
        f0 = frames;
        pulse_req();
        repeat (6) @(negedge clk);
        chk(busy, "R9 busy mid frame", busy, 1);
        probe_req = 1'b1;
        @(negedge clk);
        probe_req = 1'b0;
        wait_done();
        repeat (40) @(negedge clk);
        chk(frames == f0 + 1, "R9 extra request ignored", frames - f0, 1);
        chk(done && !busy, "R9 still finished", {done, busy}, 2);
    endtask

    task automatic t_hold();
        set_resp(8'h20, 8'h20, 8'h14);
        pulse_req();
        wait_done();
        set_resp(8'h00, 8'h11, 8'h99);
        repeat (50) @(negedge clk);
        chk(done && !cs_req, "R10 done held", done, 1);
        check_geom("R10 R5 hold", 16, 16, 8, 4096, 12);
    endtask

    initial begin
        #400000;
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        set_resp(8'h20, 8'h20, 8'h17);
        repeat (3) @(negedge clk);
        t_reset();
        t_auto();
        probe_ok(8'h11, "R4 0x11", 15, 4, 512, 0);
        probe_ok(8'h14, "R5 0x14", 16, 16, 4096, 12);
        probe_ok(8'h16, "R6 0x16", 16, 64, 16384, 0);
        probe_ok(8'h18, "R6 0x18", 18, 64, 65536, 0);
        probe_bad(8'hC2, 8'h20, 8'h17, "R7 R3 vendor mismatch");
        probe_bad(8'h20, 8'h40, 8'h17, "R7 R3 family mismatch");
        probe_bad(8'h20, 8'h20, 8'h15, "R7 unknown size");
        probe_bad(8'h17, 8'h20, 8'h20, "R7 R3 byte order");
        t_ignore();
        t_hold();
        chk(seq_bad == 0, "R2 all frames well formed", seq_bad, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule